// File: doc/BRIEF.md
# Instruction Fetch Address Sequencer

This block produces the stream of fetch-packet addresses for a multi-lane front end. It keeps a four-entry chain of program-counter slots: issued, current, next and next-next. Each slot has a valid bit, a word address and a delay-slot-taken flag. The issued, current and next slots also carry a lane-enable vector and the side information that goes with the packet. The block asks an external predictor for the successor of the next slot over one valid/ack handshake. It hands aligned packet addresses to the cache and fetch queue over a second valid/ack handshake.

A redirect input (exception, misprediction) is always accepted. It empties the issued and current slots and reloads the next and next-next slots in one cycle. Branch-state, prediction-id and fetch-pointer values come back from the predictor and travel with the packet to the fetch side. The prediction-id and fetch-pointer fields can each be switched off by a parameter. When a field is switched off, its output is held at zero and its input has no effect.

Top module: `ifa_seq_top`

## Requirements
- R1: While reset is asserted, `fetch_val` and `pred_req_val` are low and `redir_ack` is high. In the first cycle after release, `pred_req_val` is still low. The next slot comes out of reset valid, holding address `RESET_PC` (0x40 by default) with only lane 0 enabled, and the other slots come out empty.
- R2: `pred_req_val` is high exactly when the block has run for at least one cycle since reset, the next slot is valid and the next-next slot is empty. While it is high, `pred_cur_pc` and `pred_cur_ds` show the next slot. `pred_prev_pc` shows the current slot whenever that slot is valid. If the request is not acked and no redirect arrives, the request and `pred_cur_pc` hold.
- R3: An accepted prediction (`pred_req_val & pred_req_ack`) writes `pred_next_pc` and `pred_next_ds` into the next-next slot and marks it valid. In the same cycle it writes `pred_lane_en` and the side fields into the next slot.
- R4: If the issued slot is empty and the current, next and next-next slots are all valid, the current slot moves into the issued slot and the current slot becomes empty.
- R5: After the R4 step, in the same cycle and in this order: an empty current slot takes the next slot when the next-next slot is valid, and the next slot then becomes empty. After that, an empty next slot takes the address and flag of a valid next-next slot, and the next-next slot then becomes empty.
- R6: `fetch_val` follows the issued slot's valid bit. An accepted fetch (`fetch_val & fetch_ack`) empties the issued slot. An unacked packet holds unchanged.
- R7: `fetch_addr` equals the issued address minus (address mod `NB_LANES`). `fetch_lane_en` is the lane-enable vector stored in the issued slot, where bit i enables lane i.
- R8: An accepted redirect empties the issued and current slots. It loads the next slot with `redir_pc` and `redir_ds`, enables only lane 0 and clears that slot's side fields. It loads the next-next slot with `redir_next_pc` and a delay-slot flag of 0. The next-next slot is valid only if `redir_next_val` is set.
- R9: A redirect takes priority over a prediction or a fetch accepted in the same cycle. The result is the R8 state, whatever the predictor returned.
- R10: `fetch_bstate`, `fetch_pid` and `fetch_ptr` carry the values that came back with the issued packet's prediction. A field whose `HAVE_PID` or `HAVE_PTR` parameter is 0 reads as zero, and its input is ignored.
- R11: `redir_ack` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_val | output | 1 | Issued packet is valid |
| fetch_ack | input | 1 | Cache/fetch queue accepts the packet |
| fetch_addr | output | ADDR_W | Packet-aligned word address |
| fetch_lane_en | output | NB_LANES | Per-lane enables of the packet |
| fetch_bstate | output | BST_W | Branch state carried with the packet |
| fetch_pid | output | PID_W | Prediction id carried with the packet |
| fetch_ptr | output | PTR_W | Fetch pointer carried with the packet |
| pred_req_val | output | 1 | Prediction request valid |
| pred_req_ack | input | 1 | Predictor accepts and answers |
| pred_prev_pc | output | ADDR_W | Current slot address |
| pred_cur_pc | output | ADDR_W | Next slot address (PC to predict from) |
| pred_cur_ds | output | 1 | Next slot delay-slot-taken flag |
| pred_next_pc | input | ADDR_W | Predicted following PC |
| pred_next_ds | input | 1 | Delay-slot-taken flag of the predicted PC |
| pred_lane_en | input | NB_LANES | Lane enables for the packet at `pred_cur_pc` |
| pred_bstate | input | BST_W | Branch state from the predictor |
| pred_pid | input | PID_W | Prediction id from the predictor |
| pred_ptr | input | PTR_W | Fetch pointer from the predictor |
| redir_val | input | 1 | Redirect event |
| redir_ack | output | 1 | Redirect accepted |
| redir_pc | input | ADDR_W | New fetch address |
| redir_next_pc | input | ADDR_W | Address that follows the redirect target |
| redir_next_val | input | 1 | `redir_next_pc` is meaningful |
| redir_ds | input | 1 | Delay-slot-taken flag of `redir_pc` |

## Verification
The bench builds the block with four lanes, 16-bit addresses, the prediction-id field on and the fetch-pointer field off. Four lanes make every alignment offset (0 to 3) and every tail-of-packet enable pattern reachable. A narrow address space lets redirects with pseudo-random targets cover all offsets quickly. With the fetch-pointer field off, the bench checks that a non-zero `pred_ptr` never reaches `fetch_ptr`. Independent acks on both handshakes and sparse redirects put stalls, back-to-back transfers and redirects that collide with accepted predictions and fetches all within a few thousand cycles.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
  localparam int NUM_SLOTS = 4;
  // slot order along the chain: oldest (issued) first
  localparam int S_ISS = 0;
  localparam int S_CUR = 1;
  localparam int S_NXT = 2;
  localparam int S_NN  = 3;
endpackage

// File: rtl/ifa_slot_reg.sv
module ifa_slot_reg #(
  parameter int              AW     = 30,
  parameter int              NL     = 4,
  parameter int              SW     = 7,
  parameter bit              RST_V  = 1'b0,
  parameter logic [AW-1:0]   RST_A  = '0,
  parameter logic [NL-1:0]   RST_EN = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          d_v,
  input  logic [AW-1:0] d_a,
  input  logic          d_ds,
  input  logic [NL-1:0] d_en,
  input  logic [SW-1:0] d_sd,
  output logic          q_v,
  output logic [AW-1:0] q_a,
  output logic          q_ds,
  output logic [NL-1:0] q_en,
  output logic [SW-1:0] q_sd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v  <= RST_V;
      q_a  <= RST_A;
      q_ds <= 1'b0;
      q_en <= RST_EN;
      q_sd <= '0;
    end else if (ld) begin
      q_v  <= d_v;
      q_a  <= d_a;
      q_ds <= d_ds;
      q_en <= d_en;
      q_sd <= d_sd;
    end
  end
endmodule

// File: rtl/ifa_pkt_align.sv
module ifa_pkt_align #(
  parameter int AW = 30,
  parameter int NL = 4
) (
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] base
);
  localparam logic [AW-1:0] LOW_MASK = AW'(NL - 1);
  // NL is a power of two, so clearing the low bits subtracts addr mod NL
  assign base = addr & ~LOW_MASK;
endmodule

// File: rtl/ifa_chain_next.sv
module ifa_chain_next
  import ifa_pkg::*;
#(
  parameter int AW = 30,
  parameter int NL = 4,
  parameter int SW = 7
) (
  input  logic [NUM_SLOTS-1:0]         q_v,
  input  logic [NUM_SLOTS-1:0][AW-1:0] q_a,
  input  logic [NUM_SLOTS-1:0]         q_ds,
  input  logic [NUM_SLOTS-1:0][NL-1:0] q_en,
  input  logic [NUM_SLOTS-1:0][SW-1:0] q_sd,
  input  logic                         pred_fire,
  input  logic [AW-1:0]                pred_pc,
  input  logic                         pred_ds,
  input  logic [NL-1:0]                pred_en,
  input  logic [SW-1:0]                pred_sd,
  input  logic                         fetch_fire,
  input  logic                         redir_fire,
  input  logic [AW-1:0]                redir_pc,
  input  logic                         redir_ds,
  input  logic [AW-1:0]                redir_next_pc,
  input  logic                         redir_next_val,
  output logic [NUM_SLOTS-1:0]         d_v,
  output logic [NUM_SLOTS-1:0][AW-1:0] d_a,
  output logic [NUM_SLOTS-1:0]         d_ds,
  output logic [NUM_SLOTS-1:0][NL-1:0] d_en,
  output logic [NUM_SLOTS-1:0][SW-1:0] d_sd,
  output logic [NUM_SLOTS-1:0]         ld
);
  localparam logic [NL-1:0] LANE0 = NL'(1);

  logic can_issue, can_adv, can_fill, upd;

  assign can_issue = ~q_v[S_ISS] & q_v[S_CUR] & q_v[S_NXT] & q_v[S_NN];
  assign can_adv   = ~q_v[S_CUR] & q_v[S_NXT] & q_v[S_NN];
  assign can_fill  = ~q_v[S_NXT] & q_v[S_NN];
  assign upd       = redir_fire | pred_fire | fetch_fire | can_issue | can_adv | can_fill;
  assign ld        = {NUM_SLOTS{upd}};

  always_comb begin
    d_v  = q_v;
    d_a  = q_a;
    d_ds = q_ds;
    d_en = q_en;
    d_sd = q_sd;
    // prediction answer: successor into next-next, packet info into next
    if (pred_fire) begin
      d_v[S_NN]  = 1'b1;
      d_a[S_NN]  = pred_pc;
      d_ds[S_NN] = pred_ds;
      d_en[S_NXT] = pred_en;
      d_sd[S_NXT] = pred_sd;
    end
    if (fetch_fire) d_v[S_ISS] = 1'b0;
    // ordered shifts, oldest slot first
    if (!d_v[S_ISS] && d_v[S_CUR] && d_v[S_NXT] && d_v[S_NN]) begin
      d_v[S_ISS]  = 1'b1;
      d_a[S_ISS]  = d_a[S_CUR];
      d_ds[S_ISS] = d_ds[S_CUR];
      d_en[S_ISS] = d_en[S_CUR];
      d_sd[S_ISS] = d_sd[S_CUR];
      d_v[S_CUR]  = 1'b0;
    end
    if (!d_v[S_CUR] && d_v[S_NXT] && d_v[S_NN]) begin
      d_v[S_CUR]  = 1'b1;
      d_a[S_CUR]  = d_a[S_NXT];
      d_ds[S_CUR] = d_ds[S_NXT];
      d_en[S_CUR] = d_en[S_NXT];
      d_sd[S_CUR] = d_sd[S_NXT];
      d_v[S_NXT]  = 1'b0;
    end
    if (!d_v[S_NXT] && d_v[S_NN]) begin
      d_v[S_NXT]  = 1'b1;
      d_a[S_NXT]  = d_a[S_NN];
      d_ds[S_NXT] = d_ds[S_NN];
      d_v[S_NN]   = 1'b0;
    end
    // redirect overrides everything above
    if (redir_fire) begin
      d_v[S_ISS]  = 1'b0;
      d_v[S_CUR]  = 1'b0;
      d_v[S_NXT]  = 1'b1;
      d_a[S_NXT]  = redir_pc;
      d_ds[S_NXT] = redir_ds;
      d_en[S_NXT] = LANE0;
      d_sd[S_NXT] = '0;
      d_v[S_NN]   = redir_next_val;
      d_a[S_NN]   = redir_next_pc;
      d_ds[S_NN]  = 1'b0;
    end
  end
endmodule

// File: rtl/ifa_seq_top.sv
module ifa_seq_top
  import ifa_pkg::*;
#(
  parameter int            NB_LANES = 4,
  parameter int            ADDR_W   = 30,
  parameter int            BST_W    = 2,
  parameter int            PID_W    = 3,
  parameter int            PTR_W    = 2,
  parameter bit            HAVE_PID = 1'b1,
  parameter bit            HAVE_PTR = 1'b1,
  parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'('h40)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                fetch_val,
  input  logic                fetch_ack,
  output logic [ADDR_W-1:0]   fetch_addr,
  output logic [NB_LANES-1:0] fetch_lane_en,
  output logic [BST_W-1:0]    fetch_bstate,
  output logic [PID_W-1:0]    fetch_pid,
  output logic [PTR_W-1:0]    fetch_ptr,
  output logic                pred_req_val,
  input  logic                pred_req_ack,
  output logic [ADDR_W-1:0]   pred_prev_pc,
  output logic [ADDR_W-1:0]   pred_cur_pc,
  output logic                pred_cur_ds,
  input  logic [ADDR_W-1:0]   pred_next_pc,
  input  logic                pred_next_ds,
  input  logic [NB_LANES-1:0] pred_lane_en,
  input  logic [BST_W-1:0]    pred_bstate,
  input  logic [PID_W-1:0]    pred_pid,
  input  logic [PTR_W-1:0]    pred_ptr,
  input  logic                redir_val,
  output logic                redir_ack,
  input  logic [ADDR_W-1:0]   redir_pc,
  input  logic [ADDR_W-1:0]   redir_next_pc,
  input  logic                redir_next_val,
  input  logic                redir_ds
);
  localparam int SW = BST_W + PID_W + PTR_W;

  logic [NUM_SLOTS-1:0]             q_v, d_v, ld;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] q_a, d_a;
  logic [NUM_SLOTS-1:0]             q_ds, d_ds;
  logic [NUM_SLOTS-1:0][NB_LANES-1:0] q_en, d_en;
  logic [NUM_SLOTS-1:0][SW-1:0]     q_sd, d_sd;

  logic            live_q, live_d;
  logic            pred_fire, fetch_fire, redir_fire;
  logic [PID_W-1:0] pid_in;
  logic [PTR_W-1:0] ptr_in;
  logic [SW-1:0]    pred_sd;
  logic [SW-1:0]    iss_sd;

  // run flag: predictions are offered from the second cycle after reset
  assign live_d = 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= live_d;
  end

  assign pid_in  = HAVE_PID ? pred_pid : '0;
  assign ptr_in  = HAVE_PTR ? pred_ptr : '0;
  assign pred_sd = {pred_bstate, pid_in, ptr_in};

  assign redir_ack    = 1'b1;
  assign pred_req_val = live_q & q_v[S_NXT] & ~q_v[S_NN];
  assign fetch_val    = q_v[S_ISS];
  assign pred_fire    = pred_req_val & pred_req_ack;
  assign fetch_fire   = fetch_val & fetch_ack;
  assign redir_fire   = redir_val & redir_ack;

  assign pred_prev_pc = q_a[S_CUR];
  assign pred_cur_pc  = q_a[S_NXT];
  assign pred_cur_ds  = q_ds[S_NXT];

  ifa_chain_next #(.AW(ADDR_W), .NL(NB_LANES), .SW(SW)) u_next (
    .q_v(q_v), .q_a(q_a), .q_ds(q_ds), .q_en(q_en), .q_sd(q_sd),
    .pred_fire(pred_fire), .pred_pc(pred_next_pc), .pred_ds(pred_next_ds),
    .pred_en(pred_lane_en), .pred_sd(pred_sd),
    .fetch_fire(fetch_fire),
    .redir_fire(redir_fire), .redir_pc(redir_pc), .redir_ds(redir_ds),
    .redir_next_pc(redir_next_pc), .redir_next_val(redir_next_val),
    .d_v(d_v), .d_a(d_a), .d_ds(d_ds), .d_en(d_en), .d_sd(d_sd), .ld(ld)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    ifa_slot_reg #(
      .AW(ADDR_W), .NL(NB_LANES), .SW(SW),
      .RST_V (s == S_NXT),
      .RST_A (s == S_NXT ? RESET_PC : '0),
      .RST_EN(s == S_NXT ? NB_LANES'(1) : '0)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .ld(ld[s]),
      .d_v(d_v[s]), .d_a(d_a[s]), .d_ds(d_ds[s]), .d_en(d_en[s]), .d_sd(d_sd[s]),
      .q_v(q_v[s]), .q_a(q_a[s]), .q_ds(q_ds[s]), .q_en(q_en[s]), .q_sd(q_sd[s])
    );
  end

  ifa_pkt_align #(.AW(ADDR_W), .NL(NB_LANES)) u_align (
    .addr(q_a[S_ISS]),
    .base(fetch_addr)
  );

  assign fetch_lane_en = q_en[S_ISS];
  assign iss_sd        = q_sd[S_ISS];
  assign fetch_bstate  = iss_sd[SW-1 -: BST_W];
  assign fetch_pid     = iss_sd[PTR_W +: PID_W];
  assign fetch_ptr     = iss_sd[PTR_W-1:0];

  // R8: a redirect empties the issued slot
  assert_redir_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_val |=> !fetch_val);
  // R8: redirect target becomes the PC offered for prediction
  assert_redir_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_val |=> (pred_cur_pc == $past(redir_pc)));
  // R9: a prediction accepted together with a redirect is discarded
  assert_redir_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_val && pred_req_val && pred_req_ack && !$past(redir_val))
      |=> (pred_cur_pc == $past(redir_pc)));
  // R6: an unacked packet holds
  assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_val && !fetch_ack && !redir_val) |=> (fetch_val && $stable(fetch_addr)
      && $stable(fetch_lane_en)));
  // R2: an unacked prediction request holds
  assert_pred_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_req_val && !pred_req_ack && !redir_val) |=> (pred_req_val && $stable(pred_cur_pc)));
endmodule

// File: tb/ifa_seq_top_tb_top.sv
module ifa_seq_top_tb_top;
  localparam int NL = 4;
  localparam int AW = 16;
  localparam int BW = 2;
  localparam int PW = 3;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          fetch_val, fetch_ack;
  logic [AW-1:0] fetch_addr;
  logic [NL-1:0] fetch_lane_en;
  logic [BW-1:0] fetch_bstate;
  logic [PW-1:0] fetch_pid;
  logic [TW-1:0] fetch_ptr;
  logic          pred_req_val, pred_req_ack;
  logic [AW-1:0] pred_prev_pc, pred_cur_pc, pred_next_pc;
  logic          pred_cur_ds, pred_next_ds;
  logic [NL-1:0] pred_lane_en;
  logic [BW-1:0] pred_bstate;
  logic [PW-1:0] pred_pid;
  logic [TW-1:0] pred_ptr;
  logic          redir_val, redir_ack, redir_next_val, redir_ds;
  logic [AW-1:0] redir_pc, redir_next_pc;

  ifa_seq_top #(.NB_LANES(NL), .ADDR_W(AW), .BST_W(BW), .PID_W(PW), .PTR_W(TW),
                .HAVE_PID(1'b1), .HAVE_PTR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_val(fetch_val), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr),
    .fetch_lane_en(fetch_lane_en), .fetch_bstate(fetch_bstate), .fetch_pid(fetch_pid),
    .fetch_ptr(fetch_ptr),
    .pred_req_val(pred_req_val), .pred_req_ack(pred_req_ack), .pred_prev_pc(pred_prev_pc),
    .pred_cur_pc(pred_cur_pc), .pred_cur_ds(pred_cur_ds), .pred_next_pc(pred_next_pc),
    .pred_next_ds(pred_next_ds), .pred_lane_en(pred_lane_en), .pred_bstate(pred_bstate),
    .pred_pid(pred_pid), .pred_ptr(pred_ptr),
    .redir_val(redir_val), .redir_ack(redir_ack), .redir_pc(redir_pc),
    .redir_next_pc(redir_next_pc), .redir_next_val(redir_next_val), .redir_ds(redir_ds)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference chain state
  logic          m_v  [4];
  logic [AW-1:0] m_a  [4];
  logic          m_ds [4];
  logic [NL-1:0] m_en [4];
  logic [BW-1:0] m_bs [4];
  logic [PW-1:0] m_pid[4];
  logic          m_live;
  logic [15:0]   lfsr;
  int            pkt;
  int            n_pred, n_issue, n_adv, n_redir, n_prio;

  task automatic mv(input int dst, input int src);
    m_v[dst] = 1'b1; m_a[dst] = m_a[src]; m_ds[dst] = m_ds[src];
    m_en[dst] = m_en[src]; m_bs[dst] = m_bs[src]; m_pid[dst] = m_pid[src];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic pv, pf, af, ev;
    int   beg;
    fetch_ack = 0; pred_req_ack = 0; redir_val = 0; redir_next_val = 0; redir_ds = 0;
    redir_pc = '0; redir_next_pc = '0; pred_next_pc = '0; pred_next_ds = 0;
    pred_lane_en = '0; pred_bstate = '0; pred_pid = '0; pred_ptr = '0;
    lfsr = 16'hACE1; pkt = 1;
    n_pred = 0; n_issue = 0; n_adv = 0; n_redir = 0; n_prio = 0;
    for (int s = 0; s < 4; s++) begin
      m_v[s] = 0; m_a[s] = '0; m_ds[s] = 0; m_en[s] = '0; m_bs[s] = '0; m_pid[s] = '0;
    end
    m_v[2] = 1; m_a[2] = 16'h40; m_en[2] = 4'b0001; m_live = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "fetch_val in reset", fetch_val, 0);
    chk("R1", "pred_req_val in reset", pred_req_val, 0);
    chk("R11", "redir_ack in reset", redir_ack, 1);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pred_req_ack = lfsr[0] | lfsr[1];
      fetch_ack    = lfsr[2] | lfsr[3];
      redir_val    = (cyc > 3) && (lfsr[7:4] == 4'd0);
      redir_next_val = lfsr[8];
      redir_ds     = lfsr[9];
      redir_pc     = {4'h0, lfsr[11:0]};
      redir_next_pc = {4'h0, lfsr[11:0]} + 16'd5;
      // predictor answer derived from the next slot address
      beg = int'(m_a[2] % NL);
      for (int l = 0; l < NL; l++) pred_lane_en[l] = (l >= beg);
      pred_next_ds = ((pkt % 7) == 0);
      pred_next_pc = pred_next_ds ? m_a[2] + 16'h40 : m_a[2] + 16'(NL - beg);
      pred_bstate  = lfsr[13:12];
      pred_pid     = lfsr[15:13];
      pred_ptr     = 2'b11;
      #2;
      pv = m_live & m_v[2] & ~m_v[3];
      chk("R2", "pred_req_val", pred_req_val, pv);
      if (pv) begin
        chk("R2", "pred_cur_pc", pred_cur_pc, m_a[2]);
        chk("R2", "pred_cur_ds", pred_cur_ds, m_ds[2]);
        if (m_v[1]) chk("R2", "pred_prev_pc", pred_prev_pc, m_a[1]);
      end
      chk("R6", "fetch_val", fetch_val, m_v[0]);
      if (m_v[0]) begin
        chk("R7", "fetch_addr", fetch_addr, m_a[0] - (m_a[0] % NL));
        chk("R7", "fetch_lane_en", fetch_lane_en, m_en[0]);
        chk("R10", "fetch_bstate", fetch_bstate, m_bs[0]);
        chk("R10", "fetch_pid", fetch_pid, m_pid[0]);
        chk("R10", "fetch_ptr disabled", fetch_ptr, 0);
      end
      chk("R11", "redir_ack", redir_ack, 1);
      if (cyc == 0) chk("R1", "reset next slot 0x40", pred_cur_pc, 16'h40);

      pf = pv & pred_req_ack;
      af = m_v[0] & fetch_ack;
      ev = redir_val;
      @(posedge clk);
      // R3: prediction answer
      if (pf) begin
        m_v[3] = 1; m_a[3] = pred_next_pc; m_ds[3] = pred_next_ds;
        m_en[2] = pred_lane_en; m_bs[2] = pred_bstate; m_pid[2] = pred_pid;
        if (!ev) n_pred++;
      end
      if (af) begin m_v[0] = 0; pkt++; end
      // R4: issue
      if (!m_v[0] && m_v[1] && m_v[2] && m_v[3]) begin mv(0, 1); m_v[1] = 0; n_issue++; end
      // R5: ordered advance
      if (!m_v[1] && m_v[2] && m_v[3]) begin mv(1, 2); m_v[2] = 0; n_adv++; end
      if (!m_v[2] && m_v[3]) begin
        m_v[2] = 1; m_a[2] = m_a[3]; m_ds[2] = m_ds[3]; m_v[3] = 0;
      end
      // R8 / R9: redirect wins
      if (ev) begin
        if (pf || af) n_prio++;
        n_redir++;
        m_v[0] = 0; m_v[1] = 0;
        m_v[2] = 1; m_a[2] = redir_pc; m_ds[2] = redir_ds; m_en[2] = 4'b0001;
        m_bs[2] = '0; m_pid[2] = '0;
        m_v[3] = redir_next_val; m_a[3] = redir_next_pc; m_ds[3] = 0;
      end
      m_live = 1;
      @(negedge clk);
    end
    chk("R3", "predictions accepted seen", (n_pred > 50), 1);
    chk("R4", "issues seen", (n_issue > 50), 1);
    chk("R5", "advances seen", (n_adv > 50), 1);
    chk("R8", "redirects seen", (n_redir > 20), 1);
    chk("R9", "colliding redirects seen", (n_prio > 5), 1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule